// File: doc/BRIEF.md
# Three-Operand Ternary Ripple Adder

This block adds three unsigned three-trit numbers and a carry-in trit in one combinational pass. It returns a three-trit sum and a carry-out trit. Each trit travels on a two-bit binary code, so the block can sit in an ordinary binary datapath that holds base-3 values. A typical use is to accumulate a digit and its correction term in a single adder. A separate correction adder is then not needed.

The datapath is a chain of digit cells, least significant trit first. Each cell takes three operand trits and an incoming carry trit, and it returns one sum trit and one carry trit. A cell is built from three two-input ternary half-adder stages in series. The carries of those three stages are counted to form the cell's carry-out. The largest cell total is 2+2+2+2 = 8, so the carry never exceeds 2 and the result never needs an extra output digit. A code checker watches every input trit and reports any illegal code.

The block has no clock, no state and no handshake. Its outputs follow its inputs after the combinational delay. The stream convention therefore does not apply here. The owning pipeline stage registers the inputs and the outputs.

Top module: `tern3_adder`

## Requirements
- R1: A trit is coded on two bits, with 00 = 0, 01 = 1 and 10 = 2. In each three-trit bus, bits [1:0] hold the trit of weight 1, bits [3:2] the trit of weight 3, and bits [5:4] the trit of weight 9.
- R2: When all input codes are legal, value(sum_o) + 27 × value(cout_o) equals value(a_i) + value(b_i) + value(c_i) + value(cin_i) for every input combination.
- R3: When all inputs are legal, every trit of sum_o and cout_o uses a legal code, and cout_o lies in the range 0 to 2.
- R4: A digit cell produces sum trit = (a + b + c + k) mod 3 and carry = (a + b + c + k) div 3, where k is the carry into the cell. This holds for the largest cell total of 8.
- R5: Carries ripple from the weight-1 trit to the weight-9 trit. For example, all operand trits at 2 with a carry-in of 2 give a sum of 222 and a carry-out of 2.
- R6: bad_code_o is 1 exactly when at least one trit of a_i, b_i or c_i, or cin_i itself, carries the code 11.
- R7: While bad_code_o is 1, sum_o and cout_o are driven to all-zero codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 6 | First operand, three coded trits |
| b_i | input | 6 | Second operand, three coded trits |
| c_i | input | 6 | Third operand, three coded trits |
| cin_i | input | 2 | Carry-in trit |
| sum_o | output | 6 | Three-trit sum |
| cout_o | output | 2 | Carry-out trit, of weight 27 |
| bad_code_o | output | 1 | An input trit holds the illegal code 11 |

## Verification
The assertions are evaluated whenever an input changes. They check the arithmetic identity between the operands and the result, the legality of every output code, the zero forcing under a bad code, and that the error flag matches the presence of code 11. Only the bench's scenarios show that every one of the 59,049 legal input combinations is actually applied. They also show that each trit position of each operand, and the carry-in, is caught by the code checker on its own. The all-maximum carry chain and a single cell at its largest total are driven as named cases.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t TRIT_ZERO = 2'b00;
  localparam trit_t TRIT_BAD  = 2'b11;
  localparam int    TRIT_W    = 2;
endpackage

// File: rtl/tern_half_stage.sv
module tern_half_stage
  import tern_pkg::*;
(
  input  trit_t x_i,
  input  trit_t y_i,
  output trit_t s_o,
  output logic  k_o
);
  logic [2:0] tot;
  always_comb begin
    tot = {1'b0, x_i} + {1'b0, y_i};
    if (tot >= 3'd3) begin
      s_o = trit_t'(tot - 3'd3);
      k_o = 1'b1;
    end else begin
      s_o = tot[1:0];
      k_o = 1'b0;
    end
  end
endmodule

// File: rtl/tern_digit_cell.sv
module tern_digit_cell
  import tern_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  input  trit_t k_i,
  output trit_t s_o,
  output trit_t k_o
);
  trit_t s_ab, s_abc;
  logic  k_ab, k_abc, k_all;

  tern_half_stage u_st0 (.x_i(a_i),   .y_i(b_i), .s_o(s_ab),  .k_o(k_ab));
  tern_half_stage u_st1 (.x_i(s_ab),  .y_i(c_i), .s_o(s_abc), .k_o(k_abc));
  tern_half_stage u_st2 (.x_i(s_abc), .y_i(k_i), .s_o(s_o),   .k_o(k_all));

  // stage carries are single bits; their count is the cell carry (0..2)
  assign k_o = {1'b0, k_ab} + {1'b0, k_abc} + {1'b0, k_all};
endmodule

// File: rtl/tern_code_check.sv
module tern_code_check
  import tern_pkg::*;
#(
  parameter int NTRIT = 3
) (
  input  logic [TRIT_W*NTRIT-1:0] a_i,
  input  logic [TRIT_W*NTRIT-1:0] b_i,
  input  logic [TRIT_W*NTRIT-1:0] c_i,
  input  trit_t                   cin_i,
  output logic                    bad_o
);
  logic [NTRIT-1:0] pos_bad;
  for (genvar g = 0; g < NTRIT; g++) begin : g_pos
    assign pos_bad[g] = (a_i[TRIT_W*g +: TRIT_W] == TRIT_BAD) ||
                        (b_i[TRIT_W*g +: TRIT_W] == TRIT_BAD) ||
                        (c_i[TRIT_W*g +: TRIT_W] == TRIT_BAD);
  end
  assign bad_o = (|pos_bad) || (cin_i == TRIT_BAD);
endmodule

// File: rtl/tern3_adder.sv
module tern3_adder
  import tern_pkg::*;
#(
  parameter int NTRIT = 3
) (
  input  logic [2*NTRIT-1:0] a_i,
  input  logic [2*NTRIT-1:0] b_i,
  input  logic [2*NTRIT-1:0] c_i,
  input  logic [1:0]         cin_i,
  output logic [2*NTRIT-1:0] sum_o,
  output logic [1:0]         cout_o,
  output logic               bad_code_o
);
  localparam int BUS_W = TRIT_W * NTRIT;

  trit_t             chain [NTRIT+1];
  logic [BUS_W-1:0]  raw_sum;
  logic              bad;

  assign chain[0] = cin_i;

  for (genvar g = 0; g < NTRIT; g++) begin : g_cell
    tern_digit_cell u_cell (
      .a_i (a_i[TRIT_W*g +: TRIT_W]),
      .b_i (b_i[TRIT_W*g +: TRIT_W]),
      .c_i (c_i[TRIT_W*g +: TRIT_W]),
      .k_i (chain[g]),
      .s_o (raw_sum[TRIT_W*g +: TRIT_W]),
      .k_o (chain[g+1])
    );
  end

  tern_code_check #(.NTRIT(NTRIT)) u_chk_code (
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .cin_i(cin_i), .bad_o(bad)
  );

  assign bad_code_o = bad;
  assign sum_o      = bad ? '0 : raw_sum;
  assign cout_o     = bad ? TRIT_ZERO : chain[NTRIT];
endmodule

// File: rtl/tern3_adder_chk.sv
module tern3_adder_chk #(
  parameter int NTRIT = 3
) (
  input logic [2*NTRIT-1:0] a_i,
  input logic [2*NTRIT-1:0] b_i,
  input logic [2*NTRIT-1:0] c_i,
  input logic [1:0]         cin_i,
  input logic [2*NTRIT-1:0] sum_o,
  input logic [1:0]         cout_o,
  input logic               bad_code_o
);
  function automatic int bus_val(input logic [2*NTRIT-1:0] v);
    int acc = 0;
    int w = 1;
    for (int i = 0; i < NTRIT; i++) begin
      acc = acc + int'(v[2*i +: 2]) * w;
      w = w * 3;
    end
    return acc;
  endfunction

  function automatic bit has_eleven(input logic [2*NTRIT-1:0] v);
    bit f = 1'b0;
    for (int i = 0; i < NTRIT; i++) f = f | (v[2*i +: 2] == 2'b11);
    return f;
  endfunction

  int  pow_top;
  bit  any_bad;
  always_comb begin
    pow_top = 1;
    for (int i = 0; i < NTRIT; i++) pow_top = pow_top * 3;
    any_bad = has_eleven(a_i) | has_eleven(b_i) | has_eleven(c_i) | (cin_i == 2'b11);
    if (!$isunknown({a_i, b_i, c_i, cin_i})) begin
      a_r6_flag_match: assert (bad_code_o == any_bad)
        else $error("R6 flag %0b expected %0b", bad_code_o, any_bad);
      if (bad_code_o) begin
        a_r7_zero_out: assert (sum_o == '0 && cout_o == 2'b00)
          else $error("R7 outputs not zero under bad code");
      end else begin
        a_r3_legal_out: assert (!has_eleven(sum_o) && cout_o != 2'b11)
          else $error("R3 illegal output code");
        a_r2_exact_sum: assert (bus_val(sum_o) + int'(cout_o) * pow_top ==
                                bus_val(a_i) + bus_val(b_i) + bus_val(c_i) + int'(cin_i))
          else $error("R2 arithmetic identity broken");
      end
    end
  end
endmodule

bind tern3_adder tern3_adder_chk #(.NTRIT(NTRIT)) u_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .bad_code_o(bad_code_o)
);

// File: tb/sim_tern3_adder.sv
`timescale 1ns/1ps
module sim_tern3_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [5:0] a, b, c, s;
  logic [1:0] ci, co;
  logic       bad;

  tern3_adder u0 (.a_i(a), .b_i(b), .c_i(c), .cin_i(ci),
                  .sum_o(s), .cout_o(co), .bad_code_o(bad));

  typedef struct {
    logic [5:0] s;
    logic [1:0] co;
    logic       bad;
    string      tag;
  } exp_t;
  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [5:0] enc3(input int v);
    logic [5:0] r = '0;
    int x = v;
    for (int i = 0; i < 3; i++) begin
      r[2*i +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic int dec3(input logic [5:0] v);
    return int'(v[1:0]) + 3 * int'(v[3:2]) + 9 * int'(v[5:4]);
  endfunction

  function automatic bit ill(input logic [5:0] v);
    return (v[1:0] == 2'b11) || (v[3:2] == 2'b11) || (v[5:4] == 2'b11);
  endfunction

  task automatic drive(input logic [5:0] av, bv, cv, input logic [1:0] cv_in, input string tag);
    exp_t e;
    int tot;
    @(posedge clk);
    a = av; b = bv; c = cv; ci = cv_in;
    e.tag = tag;
    if (ill(av) || ill(bv) || ill(cv) || cv_in == 2'b11) begin
      e.s = '0; e.co = 2'b00; e.bad = 1'b1;
    end else begin
      tot = dec3(av) + dec3(bv) + dec3(cv) + int'(cv_in);
      e.s = enc3(tot % 27); e.co = 2'(tot / 27); e.bad = 1'b0;
    end
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (s !== e.s || co !== e.co || bad !== e.bad) begin
        n_bad++;
        $display("FAIL %s: got sum=%b cout=%b bad=%b, expected sum=%b cout=%b bad=%b",
                 e.tag, s, co, bad, e.s, e.co, e.bad);
      end
    end
  end

  initial begin
    a = '0; b = '0; c = '0; ci = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(6'b000000, 6'b000000, 6'b000000, 2'b00, "R2 zero");
    drive(6'b000110, 6'b000000, 6'b000000, 2'b00, "R1 code 012");
    drive(6'b100000, 6'b010000, 6'b000001, 2'b10, "R1 weights");
    drive(6'b000010, 6'b000010, 6'b000010, 2'b10, "R4 cell max 8");
    drive(6'b000001, 6'b000010, 6'b000000, 2'b00, "R4 cell total 3");
    drive(6'b101010, 6'b101010, 6'b101010, 2'b10, "R5 full ripple");
    drive(6'b001010, 6'b000001, 6'b000000, 2'b00, "R5 carry two trits");
    for (int p = 0; p < 3; p++) begin
      logic [5:0] m;
      m = 6'b000101 | (6'b000011 << (2*p));
      drive(m, 6'b000000, 6'b000000, 2'b00, "R6,R7 operand a");
      drive(6'b000000, m, 6'b000000, 2'b01, "R6,R7 operand b");
      drive(6'b000000, 6'b000000, m, 2'b10, "R6,R7 operand c");
    end
    drive(6'b010101, 6'b000000, 6'b000000, 2'b11, "R6,R7 carry-in");
    for (int av = 0; av < 27; av++)
      for (int bv = 0; bv < 27; bv++)
        for (int cv = 0; cv < 27; cv++)
          for (int k = 0; k < 3; k++)
            drive(enc3(av), enc3(bv), enc3(cv), 2'(k), "R2,R3 sweep");
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule